// File: doc/BRIEF.md
# Addressable serial attenuation receiver

This block is the device-side receiver for a serially programmed 7-bit step attenuator. A host drives three asynchronous pins: a data line, a shift clock and a latch strobe. It shares them among up to eight receivers, and each receiver has a 3-bit address set by strap pins. The block samples the pins into its own system clock and shifts 16-bit frames in while the strobe is low. Each frame is an 8-bit attenuation word followed by an 8-bit address word. When the strobe rises, the attenuation code goes to the output register only if the address matches the straps.

The output code counts in steps of 0.25 dB, and reset sets it to full attenuation (all ones). Two sticky flags report host errors. One is a set top bit of the attenuation word in a frame addressed to this receiver. The other is a strobe that arrives after a bit count other than 16. The system clock must run at least eight times faster than the serial shift clock.

Top module: `atten_serial_rx`

## Requirements
- R1: After reset the attenuation output is 7'h7F and both error flags are 0.
- R2: Frame bits arrive least significant first. Bits 0..7 of the frame are the attenuation word and bits 8..15 are the address word. On a matching strobe the output takes frame bits 6..0.
- R3: On a rising strobe the output is loaded only when frame bits 10..8 equal the strap pins. On a mismatch the output keeps its previous value.
- R4: Frame bits 15..11 take no part in the address comparison.
- R5: Shifting while the strobe is low leaves the output unchanged.
- R6: Shift clock edges while the strobe is high do not move the frame register.
- R7: The D7 flag is set when a matching strobe sees frame bit 7 at 1, and the code is still loaded. A set bit 7 in a mismatched frame does not set the flag. Once set, the flag stays set until reset.
- R8: The length flag is set when the strobe rises after a number of shifts other than 16. A count of exactly 16 leaves it clear. Each rising strobe restarts the count, and the flag stays set until reset.
- R9: If a shift clock rise and a strobe rise are sampled in the same system cycle, the shift is suppressed and the commit uses the frame as it stood before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data_i | input | 1 | Serial data pin (asynchronous) |
| ser_clk_i | input | 1 | Serial shift clock pin (asynchronous) |
| ser_latch_i | input | 1 | Latch strobe pin (asynchronous) |
| strap_addr_i | input | 3 | Static receiver address |
| atten_o | output | 7 | Committed attenuation code, 0.25 dB per LSB |
| d7_err_o | output | 1 | Sticky flag: bit 7 set in a matching frame |
| len_err_o | output | 1 | Sticky flag: strobe after a bit count other than 16 |

## Verification
A rising shift clock and a rising strobe can be seen in the same sampled cycle. The block must then treat the strobe as winning: there is no shift, the bit count stays at 15 and a length error is raised. The bench provokes this by raising both pins in the same system cycle after only fifteen bits. The frame is chosen so that the fifteen-bit contents fail the address compare while sixteen bits would have matched. A correct design therefore leaves the output unchanged and sets the length flag, and the cycle model judges every cycle around the event.

// File: rtl/atten_rx_pkg.sv
// Package: shared constants for the serial attenuation receiver.
// Assumes one frame = attenuation word followed by address word.
package atten_rx_pkg;
    localparam int FRAME_BITS_DEF = 16;
    localparam int WORD_BITS_DEF  = 8;
    localparam int CODE_BITS_DEF  = 7;
    localparam int ADDR_BITS_DEF  = 3;
    localparam int SYNC_STAGES_DEF = 2;
    // Index of each serial pin inside the synchronised pin vector.
    typedef enum int {
        PIN_DATA  = 0,
        PIN_SCLK  = 1,
        PIN_LATCH = 2
    } ser_pin_e;
    localparam int N_PINS = 3;
endpackage

// File: rtl/atten_pin_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each pin is stable for several system cycles between changes.
module atten_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        // Move the pin value one stage deeper each cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pins_i[g]};
        end
        assign lvl_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/atten_edge.sv
// Module: rising-edge detector for synchronised levels.
// Assumes inputs are already in the clk domain; output is a one-cycle pulse.
module atten_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;
    // Remember last cycle's level of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end
    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/atten_frame_shift.sv
// Module: LSB-first frame shift register with a saturating bit counter.
// Assumes shift_en and clear_i never assert in the same cycle.
module atten_frame_shift #(
    parameter int FRAME_BITS = 16,
    parameter int WORD_BITS  = 8,
    parameter int CODE_BITS  = 7,
    parameter int ADDR_BITS  = 3,
    parameter int CNT_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 bit_i,
    input  logic                 clear_i,
    output logic [CODE_BITS-1:0] code_o,
    output logic                 top_o,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic [CNT_W-1:0]     count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    logic [FRAME_BITS-1:0] frame_q;

    // New bit enters at the top so the first bit ends at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_q <= '0;
        else if (shift_en) frame_q <= {bit_i, frame_q[FRAME_BITS-1:1]};
    end

    // Count shifts since the last strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                              count_o <= '0;
        else if (clear_i)                        count_o <= '0;
        else if (shift_en && count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end

    assign code_o = frame_q[CODE_BITS-1:0];
    assign top_o  = frame_q[WORD_BITS-1];
    assign addr_o = frame_q[WORD_BITS +: ADDR_BITS];
endmodule

// File: rtl/atten_commit.sv
// Module: address compare, output register and sticky error flags.
// Assumes latch_rise is a single-cycle pulse per strobe.
module atten_commit #(
    parameter int FRAME_BITS = 16,
    parameter int CODE_BITS  = 7,
    parameter int ADDR_BITS  = 3,
    parameter int CNT_W      = 6,
    parameter logic [CODE_BITS-1:0] RESET_CODE = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 latch_rise,
    input  logic [CODE_BITS-1:0] code_i,
    input  logic                 top_i,
    input  logic [ADDR_BITS-1:0] addr_i,
    input  logic [ADDR_BITS-1:0] strap_i,
    input  logic [CNT_W-1:0]     count_i,
    output logic [CODE_BITS-1:0] atten_o,
    output logic                 d7_err_o,
    output logic                 len_err_o
);
    logic hit;
    assign hit = latch_rise && (addr_i == strap_i);

    // Load the code only on an addressed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   atten_o <= RESET_CODE;
        else if (hit) atten_o <= code_i;
    end

    // Sticky flag for a set top bit in an addressed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)            d7_err_o <= 1'b0;
        else if (hit && top_i) d7_err_o <= 1'b1;
    end

    // Sticky flag for a strobe after a wrong bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) len_err_o <= 1'b0;
        else if (latch_rise && count_i != CNT_W'(FRAME_BITS)) len_err_o <= 1'b1;
    end
endmodule

// File: rtl/atten_serial_rx.sv
// Module: top of the addressable serial attenuation receiver.
// Assumes clk runs at least 8x the serial shift clock; pins are asynchronous.
module atten_serial_rx
    import atten_rx_pkg::*;
#(
    parameter int FRAME_BITS  = FRAME_BITS_DEF,
    parameter int WORD_BITS   = WORD_BITS_DEF,
    parameter int CODE_BITS   = CODE_BITS_DEF,
    parameter int ADDR_BITS   = ADDR_BITS_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_data_i,
    input  logic                 ser_clk_i,
    input  logic                 ser_latch_i,
    input  logic [ADDR_BITS-1:0] strap_addr_i,
    output logic [CODE_BITS-1:0] atten_o,
    output logic                 d7_err_o,
    output logic                 len_err_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1) + 1;

    logic [N_PINS-1:0]    pin_lvl;
    logic [1:0]           rise;
    logic                 sclk_rise, latch_rise, latch_lvl, shift_en;
    logic [CODE_BITS-1:0] code;
    logic                 top_bit;
    logic [ADDR_BITS-1:0] addr;
    logic [CNT_W-1:0]     count;

    atten_pin_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pins_i({ser_latch_i, ser_clk_i, ser_data_i}),
        .lvl_o(pin_lvl)
    );

    atten_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .lvl_i({pin_lvl[PIN_LATCH], pin_lvl[PIN_SCLK]}),
        .rise_o(rise)
    );

    assign sclk_rise  = rise[0];
    assign latch_rise = rise[1];
    assign latch_lvl  = pin_lvl[PIN_LATCH];
    assign shift_en   = sclk_rise && !latch_lvl;

    atten_frame_shift #(
        .FRAME_BITS(FRAME_BITS), .WORD_BITS(WORD_BITS), .CODE_BITS(CODE_BITS),
        .ADDR_BITS(ADDR_BITS), .CNT_W(CNT_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_i(pin_lvl[PIN_DATA]),
        .clear_i(latch_rise), .code_o(code), .top_o(top_bit), .addr_o(addr),
        .count_o(count)
    );

    atten_commit #(
        .FRAME_BITS(FRAME_BITS), .CODE_BITS(CODE_BITS), .ADDR_BITS(ADDR_BITS),
        .CNT_W(CNT_W)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .latch_rise(latch_rise), .code_i(code),
        .top_i(top_bit), .addr_i(addr), .strap_i(strap_addr_i), .count_i(count),
        .atten_o(atten_o), .d7_err_o(d7_err_o), .len_err_o(len_err_o)
    );
endmodule

// File: rtl/atten_serial_rx_chk.sv
// Module: property checker for atten_serial_rx, attached by bind.
// Assumes it observes the top's internal frame fields and strobe pulses.
module atten_serial_rx_chk #(
    parameter int CODE_BITS = 7,
    parameter int ADDR_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 latch_lvl,
    input logic                 latch_rise,
    input logic [CODE_BITS-1:0] code,
    input logic                 top_bit,
    input logic [ADDR_BITS-1:0] addr,
    input logic [ADDR_BITS-1:0] strap,
    input logic [CODE_BITS-1:0] atten,
    input logic                 d7_err,
    input logic                 len_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (atten == {CODE_BITS{1'b1}}) && !d7_err && !len_err);

    p_match_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise && (addr == strap) |=> atten == $past(code));

    p_mismatch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise && (addr != strap) |=> $stable(atten));

    p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> $stable(atten));

    p_frozen_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lvl |=> $stable(code) && $stable(addr) && $stable(top_bit));

    p_d7_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d7_err |=> d7_err);

    p_d7_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise && (addr != strap) && !d7_err |=> !d7_err);

    p_len_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);
endmodule

bind atten_serial_rx atten_serial_rx_chk #(
    .CODE_BITS(CODE_BITS), .ADDR_BITS(ADDR_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .latch_lvl(latch_lvl), .latch_rise(latch_rise),
    .code(code), .top_bit(top_bit), .addr(addr), .strap(strap_addr_i),
    .atten(atten_o), .d7_err(d7_err_o), .len_err(len_err_o)
);

// File: tb/sim_atten_serial_rx.sv
// Bench: drives serial frames and compares against a behavioural model each cycle.
module sim_atten_serial_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       si = 1'b0, sck = 1'b0, le = 1'b0;
    logic [2:0] strap = 3'd3;
    logic [6:0] att;
    logic       d7e, lene;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    atten_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_data_i(si), .ser_clk_i(sck),
        .ser_latch_i(le), .strap_addr_i(strap), .atten_o(att),
        .d7_err_o(d7e), .len_err_o(lene)
    );

    // Behavioural model state
    bit         mq[$];
    logic [2:0] hq[$];
    int         m_cnt;
    logic [6:0] m_att;
    bit         m_d7, m_len;

    task automatic model_reset();
        mq.delete();
        for (int i = 0; i < 16; i++) mq.push_back(1'b0);
        hq.delete();
        for (int i = 0; i < 3; i++) hq.push_back(3'b000);
        m_cnt = 0; m_att = 7'h7F; m_d7 = 1'b0; m_len = 1'b0;
    endtask

    initial model_reset();

    // Pins take three cycles to reach the edge logic; react to the delayed samples.
    always @(posedge clk) begin
        logic [2:0] nw, od;
        int a;
        if (!rst_n) model_reset();
        else begin
            od = hq[0]; nw = hq[1];
            if (nw[1] && !od[1] && !nw[2]) begin
                mq.push_back(nw[0]); void'(mq.pop_front());
                if (m_cnt < 63) m_cnt++;
            end
            if (nw[2] && !od[2]) begin
                if (m_cnt != 16) m_len = 1'b1;
                m_cnt = 0;
                a = int'(mq[8]) + 2 * int'(mq[9]) + 4 * int'(mq[10]);
                if (a == int'(strap)) begin
                    for (int i = 0; i < 7; i++) m_att[i] = mq[i];
                    if (mq[7]) m_d7 = 1'b1;
                end
            end
            hq.push_back({le, sck, si}); void'(hq.pop_front());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 cycle atten", int'(att), int'(m_att));
            chk("R7 cycle d7 flag", int'(d7e), int'(m_d7));
            chk("R8 cycle length flag", int'(lene), int'(m_len));
        end
    end

    task automatic send_bit(input bit b);
        @(negedge clk); si = b; sck = 1'b0;
        repeat (8) @(negedge clk);
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
    endtask

    task automatic latch_pulse();
        repeat (4) @(negedge clk);
        le = 1'b1;
        repeat (8) @(negedge clk);
        le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset atten", int'(att), 'h7F);
        chk("R1 reset d7 flag", int'(d7e), 0);
        chk("R1 reset length flag", int'(lene), 0);

        // R5: output untouched mid-frame; R2/R3: matching frame loads
        send_frame(16'h0342, 8);
        repeat (4) @(negedge clk);
        chk("R5 hold during shift", int'(att), 'h7F);
        for (int i = 8; i < 16; i++) send_bit(16'h0342 >> i);
        latch_pulse();
        chk("R2 matching load", int'(att), 'h42);
        chk("R8 full frame no length flag", int'(lene), 0);

        // R3: wrong address keeps output
        send_frame(16'h0511, 16); latch_pulse();
        chk("R3 mismatch hold", int'(att), 'h42);

        // R7: top bit in mismatched frame ignored
        send_frame(16'h0480, 16); latch_pulse();
        chk("R7 mismatched top bit no flag", int'(d7e), 0);
        chk("R7 mismatched top bit hold", int'(att), 'h42);

        // R4: upper address bits ignored
        send_frame(16'hFB27, 16); latch_pulse();
        chk("R4 upper address ignored", int'(att), 'h27);

        // R7: top bit in matching frame flags and still loads
        send_frame(16'h03D5, 16); latch_pulse();
        chk("R7 matching top bit load", int'(att), 'h55);
        chk("R7 matching top bit flag", int'(d7e), 1);

        // R8: short frame
        send_frame(16'h0011, 12); latch_pulse();
        chk("R8 short frame flag", int'(lene), 1);

        // R6: clocks with strobe high must not shift
        send_frame(16'h3315, 16); latch_pulse();
        chk("R6 base frame load", int'(att), 'h15);
        repeat (4) @(negedge clk);
        le = 1'b1;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            si = 1'b1; sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
            repeat (8) @(negedge clk);
        end
        le = 1'b0; si = 1'b0;
        repeat (8) @(negedge clk);
        latch_pulse();
        chk("R6 no shift while strobe high", int'(att), 'h15);

        // R9: strobe and shift clock rise together after 15 bits
        send_frame(16'h0305, 15);
        @(negedge clk); si = 1'b0;
        repeat (8) @(negedge clk);
        sck = 1'b1; le = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
        repeat (8) @(negedge clk);
        le = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 strobe wins, output held", int'(att), 'h15);
        chk("R9 strobe wins, length flag", int'(lene), 1);

        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule